// File: doc/BRIEF.md
# Reversible Gate Cascade Evaluator

This block evaluates a cascade of reversible logic gates on an N-line bit vector. A gate program is first loaded into a small internal gate store, one entry per accepted write. Each entry carries a gate kind, a control mask over the lines and up to two target line indices. A start request then latches an input vector and a gate count. The block applies gate 0, gate 1 and so on, one gate per clock, and updates the line vector after every gate. After the last gate it pulses `done` and presents the final vector.

All gate kinds share one control encoding: a gate fires only when every line selected in its control mask held 1 before the gate. Three kinds are evaluated: a multi-control inverter, a multi-control swap and a two-target Peres-style gate. The two quantum square-root-of-NOT kinds, and any unused kind code, cannot be represented on classical bits. The block leaves the vector unchanged for such an entry and raises a sticky `unsup` flag for that run.

The write port follows valid/ready rules. A write is taken on any clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole of a run, so a writer has to hold its entry until the run ends. No write is buffered while `wr_ready` is low. `start`, `busy`, `done` and `unsup` are plain level or pulse pins.

Top module: `rgc_cascade`

## Requirements
- R1: After reset, `busy`, `done` and `unsup` are 0, `vec_out` is all zeros and `wr_ready` is 1.
- R2: An entry is stored at `wr_addr` on an edge where `wr_valid` and `wr_ready` are both 1. `wr_ready` is 0 while `busy` is 1, and a write offered then leaves the store unchanged.
- R3: A `start` seen while idle latches `vec_in` and `gate_cnt`. A count above DEPTH is taken as DEPTH. Entries 0 to count-1 are applied in ascending order, one per edge. Counting the start edge as edge 0, `busy` is high after edges 0 to count-1, and `done` is high only after edge count, for exactly one cycle.
- R4: Kind code 0 (inverter) inverts line `tgt0` when every masked line was 1 before the gate. An all-zero mask always inverts.
- R5: Kind code 1 (swap) exchanges lines `tgt0` and `tgt1` when every masked line was 1 before the gate. Otherwise the vector is unchanged.
- R6: Kind code 2 (Peres) computes C = AND of the masked lines. It then sets `tgt0` to `tgt0` XOR C and `tgt1` to `tgt1` XOR (C AND old `tgt0`), with every operand taken before the gate.
- R7: Kind codes 3 and 4 (quantum V and V-dagger), and codes 5 to 7, leave the vector unchanged and set `unsup`. `unsup` stays set until the next accepted start clears it.
- R8: A `start` raised while `busy` is 1 is ignored. It changes neither the result nor the cycle in which `done` rises.
- R9: While idle, `vec_out` and `unsup` hold their values until the next accepted start.
- R10: A gate count of 0 gives `done` after edge 0, with `vec_out` equal to the latched `vec_in` and `unsup` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Gate entry offered |
| wr_ready | output | 1 | Gate store accepts an entry (idle) |
| wr_addr | input | AW | Gate store address |
| wr_kind | input | 3 | Kind code: 0 inverter, 1 swap, 2 Peres, 3 V, 4 V-dagger |
| wr_ctrl | input | N | Control line mask |
| wr_tgt0 | input | IW | First target line index |
| wr_tgt1 | input | IW | Second target line index |
| start | input | 1 | Begin a run (ignored while busy) |
| gate_cnt | input | CW | Number of entries to apply |
| vec_in | input | N | Initial line vector |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| unsup | output | 1 | An unsupported kind was met in this run |
| vec_out | output | N | Current or final line vector |

## Verification
The bench counts rising edges from the edge that takes `start`. At the falling edge after each rising edge it compares `busy` and `done` with the values expected for that edge, so `done` must appear exactly after edge count, with no early or late pulse. `vec_out` and `unsup` are compared with a bench model of the cascade in the `done` cycle. They are compared again several cycles later, after the inputs have been changed, to cover the hold rule. An offered write and a repeated start are applied a cycle or two into a run. Their lack of effect is read from the result of that run and of a later run that reuses the entry.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_INV   = 3'd0,
    KIND_SWAP  = 3'd1,
    KIND_PERES = 3'd2,
    KIND_QV    = 3'd3,
    KIND_QVDAG = 3'd4
  } gate_kind_e;
endpackage

// File: rtl/rgc_gate_mem.sv
module rgc_gate_mem #(
  parameter int N     = 8,
  parameter int DEPTH = 64,
  parameter int IW    = 3,
  parameter int AW    = 6
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [rgc_pkg::KIND_W-1:0] wr_kind,
  input  logic [N-1:0]              wr_ctrl,
  input  logic [IW-1:0]             wr_tgt0,
  input  logic [IW-1:0]             wr_tgt1,
  input  logic [AW-1:0]             rd_addr,
  output logic [rgc_pkg::KIND_W-1:0] rd_kind,
  output logic [N-1:0]              rd_ctrl,
  output logic [IW-1:0]             rd_tgt0,
  output logic [IW-1:0]             rd_tgt1
);
  localparam int EW = rgc_pkg::KIND_W + N + 2 * IW;

  logic [EW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= {wr_kind, wr_ctrl, wr_tgt0, wr_tgt1};
  end

  assign {rd_kind, rd_ctrl, rd_tgt0, rd_tgt1} = store[rd_addr];
endmodule

// File: rtl/rgc_gate_apply.sv
module rgc_gate_apply #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [rgc_pkg::KIND_W-1:0] kind,
  input  logic [N-1:0]               ctrl,
  input  logic [IW-1:0]              tgt0,
  input  logic [IW-1:0]              tgt1,
  input  logic [N-1:0]               vec_in,
  output logic [N-1:0]               vec_out,
  output logic                       unsup
);
  import rgc_pkg::*;

  logic [N-1:0] ctrl_ok;
  logic         fire;
  logic         bit0;
  logic         bit1;

  // per-line control test: a line passes when unmasked or high
  for (genvar g = 0; g < N; g++) begin : g_ctrl
    assign ctrl_ok[g] = vec_in[g] | ~ctrl[g];
  end
  assign fire = &ctrl_ok;
  assign bit0 = vec_in[tgt0];
  assign bit1 = vec_in[tgt1];

  always_comb begin
    vec_out = vec_in;
    unsup   = 1'b0;
    case (kind)
      KIND_INV:   vec_out[tgt0] = bit0 ^ fire;
      KIND_SWAP: begin
        if (fire) begin
          vec_out[tgt0] = bit1;
          vec_out[tgt1] = bit0;
        end
      end
      KIND_PERES: begin
        vec_out[tgt0] = bit0 ^ fire;
        vec_out[tgt1] = bit1 ^ (fire & bit0);
      end
      default:    unsup = 1'b1;
    endcase
  end
endmodule

// File: rtl/rgc_seq.sv
module rgc_seq #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cnt_in,
  output logic          load,
  output logic          step,
  output logic [AW-1:0] idx,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt_clamp;
  logic [AW-1:0] idx_q;
  logic [AW-1:0] last_q;
  logic          busy_q;
  logic          done_q;

  assign cnt_clamp = (cnt_in > CW'(DEPTH)) ? CW'(DEPTH) : cnt_in;
  assign load      = start & ~busy_q;
  assign step      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      last_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start) begin
        idx_q <= '0;
        if (cnt_clamp == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          last_q <= AW'(cnt_clamp - CW'(1));
        end
      end
    end
  end

  assign idx  = idx_q;
  assign busy = busy_q;
  assign done = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R3
  AST_IDX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (idx_q != last_q) |=> busy_q && (idx_q == $past(idx_q) + 1'b1)); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start |=> $stable(last_q)); // R8
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (idx_q != last_q) |=> !done_q); // R3
endmodule

// File: rtl/rgc_cascade.sv
module rgc_cascade #(
  parameter int N     = 8,
  parameter int DEPTH = 64,
  localparam int IW   = (N > 1) ? $clog2(N) : 1,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [AW-1:0]              wr_addr,
  input  logic [rgc_pkg::KIND_W-1:0] wr_kind,
  input  logic [N-1:0]               wr_ctrl,
  input  logic [IW-1:0]              wr_tgt0,
  input  logic [IW-1:0]              wr_tgt1,
  input  logic                       start,
  input  logic [CW-1:0]              gate_cnt,
  input  logic [N-1:0]               vec_in,
  output logic                       busy,
  output logic                       done,
  output logic                       unsup,
  output logic [N-1:0]               vec_out
);
  import rgc_pkg::*;

  logic                load;
  logic                step;
  logic [AW-1:0]       idx;
  logic [KIND_W-1:0]   cur_kind;
  logic [N-1:0]        cur_ctrl;
  logic [IW-1:0]       cur_t0;
  logic [IW-1:0]       cur_t1;
  logic [N-1:0]        next_vec;
  logic                cur_unsup;
  logic [N-1:0]        vec_q;
  logic                unsup_q;

  rgc_seq #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_in(gate_cnt),
    .load(load), .step(step), .idx(idx), .busy(busy), .done(done)
  );

  rgc_gate_mem #(.N(N), .DEPTH(DEPTH), .IW(IW), .AW(AW)) u_mem (
    .clk(clk), .wr_en(wr_valid & wr_ready), .wr_addr(wr_addr),
    .wr_kind(wr_kind), .wr_ctrl(wr_ctrl), .wr_tgt0(wr_tgt0), .wr_tgt1(wr_tgt1),
    .rd_addr(idx), .rd_kind(cur_kind), .rd_ctrl(cur_ctrl),
    .rd_tgt0(cur_t0), .rd_tgt1(cur_t1)
  );

  rgc_gate_apply #(.N(N), .IW(IW)) u_apply (
    .kind(cur_kind), .ctrl(cur_ctrl), .tgt0(cur_t0), .tgt1(cur_t1),
    .vec_in(vec_q), .vec_out(next_vec), .unsup(cur_unsup)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      unsup_q <= 1'b0;
    end else if (load) begin
      vec_q   <= vec_in;
      unsup_q <= 1'b0;
    end else if (step) begin
      vec_q   <= next_vec;
      if (cur_unsup) unsup_q <= 1'b1;
    end
  end

  assign wr_ready = ~busy;
  assign vec_out  = vec_q;
  assign unsup    = unsup_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(vec_out) && $stable(unsup)); // R9
  AST_UNSUP_KEEPS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cur_kind > KIND_PERES) |=> $stable(vec_q) && unsup_q); // R7
  AST_INV_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cur_kind == KIND_INV) |=> $countones(vec_q ^ $past(vec_q)) <= 1); // R4
  AST_SWAP_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cur_kind == KIND_SWAP) |=> $countones(vec_q) == $countones($past(vec_q))); // R5
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(wr_valid && wr_ready)); // R2
endmodule

// File: tb/rgc_cascade_tb.sv
module rgc_cascade_tb;
  localparam int N = 8;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [5:0] wr_addr = '0;
  logic [2:0] wr_kind = '0;
  logic [7:0] wr_ctrl = '0;
  logic [2:0] wr_tgt0 = '0;
  logic [2:0] wr_tgt1 = '0;
  logic       start = 1'b0;
  logic [6:0] gate_cnt = '0;
  logic [7:0] vec_in = '0;
  logic       busy, done, unsup;
  logic [7:0] vec_out;

  int n_chk = 0;
  int n_bad = 0;

  logic [2:0] m_kind [DEPTH];
  logic [7:0] m_ctrl [DEPTH];
  logic [2:0] m_t0   [DEPTH];
  logic [2:0] m_t1   [DEPTH];

  rgc_cascade #(.N(N), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_kind(wr_kind), .wr_ctrl(wr_ctrl),
    .wr_tgt0(wr_tgt0), .wr_tgt1(wr_tgt1), .start(start), .gate_cnt(gate_cnt),
    .vec_in(vec_in), .busy(busy), .done(done), .unsup(unsup), .vec_out(vec_out)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_gate(input logic [7:0] v, input int i);
    logic [7:0] r = v;
    logic c = ((v & m_ctrl[i]) == m_ctrl[i]);
    logic a = v[m_t0[i]];
    logic b = v[m_t1[i]];
    case (m_kind[i])
      3'd0: r[m_t0[i]] = a ^ c;
      3'd1: if (c) begin r[m_t0[i]] = b; r[m_t1[i]] = a; end
      3'd2: begin r[m_t0[i]] = a ^ c; r[m_t1[i]] = b ^ (c & a); end
      default: r = v;
    endcase
    return r;
  endfunction

  task automatic put(input int a, input int k, input logic [7:0] c, input int t0, input int t1);
    @(negedge clk);
    check(wr_ready == 1'b1, "R2 ready idle", int'(wr_ready), 1);
    wr_valid = 1'b1; wr_addr = 6'(a); wr_kind = 3'(k); wr_ctrl = c;
    wr_tgt0 = 3'(t0); wr_tgt1 = 3'(t1);
    m_kind[a] = 3'(k); m_ctrl[a] = c; m_t0[a] = 3'(t0); m_t1[a] = 3'(t1);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // runs a program; poke_start / poke_write disturb the run at edge 1
  task automatic run(input logic [7:0] vin, input int cnt, input bit poke_start,
                     input bit poke_write, input string tag);
    int ce = (cnt > DEPTH) ? DEPTH : cnt;
    logic [7:0] ev = vin;
    bit eu = 1'b0;
    bit tim_ok = 1'b1;
    int bad_k = -1;
    for (int i = 0; i < ce; i++) begin
      ev = model_gate(ev, i);
      if (m_kind[i] > 3'd2) eu = 1'b1;
    end
    @(negedge clk);
    vec_in = vin; gate_cnt = 7'(cnt); start = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= ce; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      if (k == 1 && poke_start) begin start = 1'b1; vec_in = ~vin; gate_cnt = 7'd1; end
      if (k == 2 && poke_start) start = 1'b0;
      if (k == 1 && poke_write) begin
        check(wr_ready == 1'b0, {tag, " R2 not ready busy"}, int'(wr_ready), 0);
        wr_valid = 1'b1; wr_addr = 6'd0; wr_kind = 3'd0; wr_ctrl = 8'h00; wr_tgt0 = 3'd5;
      end
      if (k == 2 && poke_write) wr_valid = 1'b0;
      if (done != (k == ce) || busy != (k < ce)) begin
        tim_ok = 1'b0;
        if (bad_k < 0) bad_k = k;
      end
      if (k < ce) @(posedge clk);
    end
    check(tim_ok, {tag, " R3 done/busy timing (first bad edge in actual)"}, bad_k, ce);
    check(vec_out == ev, {tag, " R3 result vector"}, int'(vec_out), int'(ev));
    check(unsup == eu, {tag, " R7 unsup flag"}, int'(unsup), int'(eu));
    start = 1'b0; wr_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    bit hold_u;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      m_kind[i] = 3'd0; m_ctrl[i] = 8'h00; m_t0[i] = 3'd0; m_t1[i] = 3'd1;
    end
    repeat (2) @(negedge clk);
    // R1 reset values
    check(busy == 1'b0 && done == 1'b0 && unsup == 1'b0, "R1 reset flags",
          {busy, done, unsup}, 0);
    check(vec_out == 8'h00, "R1 reset vector", int'(vec_out), 0);
    check(wr_ready == 1'b1, "R1 reset ready", int'(wr_ready), 1);
    rst_n = 1'b1;
    // fill the whole store so every run reads defined entries
    for (int i = 0; i < DEPTH; i++) put(i, 0, 8'h01, i % 8, (i + 1) % 8);

    // R4: empty mask inverts unconditionally
    put(0, 0, 8'h00, 2, 0);
    run(8'h00, 1, 0, 0, "R4 plain NOT");
    check(vec_out == 8'h04, "R4 literal NOT of line 2", int'(vec_out), 8'h04);
    // R4: two controls, fired and not fired
    put(0, 0, 8'h03, 7, 0);
    run(8'h03, 1, 0, 0, "R4 controls met");
    check(vec_out == 8'h83, "R4 literal flip", int'(vec_out), 8'h83);
    run(8'h01, 1, 0, 0, "R4 control missing");
    check(vec_out == 8'h01, "R4 literal no flip", int'(vec_out), 8'h01);
    // R5 swap, fired and not
    put(0, 1, 8'h01, 3, 6);
    run(8'h09, 1, 0, 0, "R5 swap fires");
    check(vec_out == 8'h41, "R5 literal swap", int'(vec_out), 8'h41);
    run(8'h08, 1, 0, 0, "R5 swap blocked");
    // R6 Peres on (a=0, b=1, c=2)
    put(0, 2, 8'h01, 1, 2);
    run(8'h03, 1, 0, 0, "R6 peres a=1 b=1");
    check(vec_out == 8'h05, "R6 literal b^a, c^(a&b)", int'(vec_out), 8'h05);
    run(8'h01, 1, 0, 0, "R6 peres a=1 b=0");
    // R7 unsupported in the middle, all unused codes
    put(0, 0, 8'h00, 0, 1);
    put(1, 3, 8'h01, 4, 5);
    put(2, 0, 8'h00, 6, 1);
    run(8'h00, 3, 0, 0, "R7 V between");
    check(vec_out == 8'h41, "R7 literal skip", int'(vec_out), 8'h41);
    for (int k = 4; k < 8; k++) begin
      put(1, k, 8'h00, 3, 4);
      run(8'h10, 3, 0, 0, "R7 unused code");
    end
    // R9 hold: inputs change, outputs stay
    held = vec_out; hold_u = unsup;
    @(negedge clk); vec_in = ~vec_in; gate_cnt = 7'd5;
    repeat (4) @(negedge clk);
    check(vec_out == held && unsup == hold_u, "R9 hold after done", int'(vec_out), int'(held));
    // R7 cleared by next start
    put(1, 0, 8'h00, 3, 4);
    run(8'h10, 3, 0, 0, "R7 cleared on start");
    // R10 zero count
    run(8'h5A, 0, 0, 0, "R10 zero count");
    check(vec_out == 8'h5A, "R10 literal passthrough", int'(vec_out), 8'h5A);
    // R8 restart ignored, R2 write ignored during busy
    put(0, 0, 8'h00, 1, 0);
    run(8'h21, 6, 1, 1, "R8 R2 disturbed run");
    run(8'h00, 1, 0, 0, "R2 entry 0 unchanged");
    check(vec_out == 8'h02, "R2 literal old entry", int'(vec_out), 8'h02);

    // random programs; count above DEPTH clamps (R3)
    for (int r = 0; r < 24; r++) begin
      int cnt;
      for (int i = 0; i < DEPTH; i++) begin
        int sel = int'($urandom % 20);
        int t0 = int'($urandom % 8);
        int t1 = (t0 + 1 + int'($urandom % 7)) % 8;
        int k;
        logic [7:0] c = 8'($urandom & $urandom) & ~((8'h01 << t0) | (8'h01 << t1));
        if (sel < 8) k = 0; else if (sel < 13) k = 1; else if (sel < 18) k = 2;
        else k = 3 + int'($urandom % 5);
        put(i, k, c, t0, t1);
      end
      cnt = (r == 0) ? 100 : ((r == 1) ? DEPTH : 1 + int'($urandom % DEPTH));
      run(8'($urandom), cnt, r == 2, r == 3, "R3 random program");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule